// File: doc/BRIEF.md
# Layered QoS Memory Arbiter

This block decides which of several DMA agent clusters may use one shared memory port. Each cluster raises a single request line, because its own channels were already merged by a simple rotating sub-arbiter upstream. Processor traffic never reaches this block. When the port is free, the arbiter picks one winner using three layered methods:

- **Time-division wheel.** A wheel of 16 slots gives each guaranteed agent a bounded wait and a minimum share of grants.
- **Priority fallback.** A slot whose owner is idle goes to the highest-priority requester.
- **Rotation.** Whatever remains is shared in rotating order among best-effort agents.

The winner keeps the grant until it signals done.

Two copies of the slot and priority tables are held. A plain write port lets software load the copy that is not in use while arbitration runs from the other. A control write then asks for a swap. The hardware performs the swap only at the start of a wheel turn while the port is idle, so a turn never mixes two configurations.

Top module: `mem_qos_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and a `gnt` bit is never high while the matching `req` bit is low.
- R2: With the port idle and a request present, `gnt` goes high at the next rising edge. It stays unchanged while the holder keeps `req` high and `done` low. It drops at the edge where the holder's `done` is high, and a new grant is issued no earlier than the following edge.
- R3: When the owner of the current slot (active table, index `slot_idx`) is requesting, it wins regardless of any priority.
- R4: When the slot owner is not requesting, the requester with the largest nonzero 2-bit priority level wins. On equal levels, the lower agent index wins.
- R5: When neither of the above yields a winner, the best-effort requesters (level 0) are searched in rotating order. The search starts at the agent after the last one granted through this rotation. After reset the search starts at agent 0.
- R6: `slot_idx` advances by exactly one each time a grant ends, and wraps from 15 to 0.
- R7: Write addresses are as follows, and every table write lands in the inactive table only, with no effect on grants until a swap:
  - addresses 0–15 set the owner of that slot (low 2 bits of data);
  - addresses 16–19 set the priority level of agent 0–3 (low 2 bits of data);
  - address 20 with data bit 0 set requests a swap.
- R8: `swap_pending` rises after a swap request. The swap happens only at an edge where `slot_idx` is 0 and no grant is held. At that edge `active_bank` toggles, `swap_pending` clears, and no grant is issued.
- R9: After reset `gnt` is 0, `active_bank` is 0, `swap_pending` is 0 and `slot_idx` is 0. Both tables give slot s to agent s mod 4, and every agent has level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-agent request |
| done | input | 4 | Per-agent end of granted access |
| gnt | output | 4 | One-hot grant |
| cfg_we | input | 1 | Table/control write strobe |
| cfg_addr | input | 5 | Write address |
| cfg_wdata | input | 4 | Write data |
| active_bank | output | 1 | Table copy in use |
| swap_pending | output | 1 | Swap requested but not yet performed |
| slot_idx | output | 4 | Current wheel slot |

## Verification
The hardest state to reach is the table swap. It needs a pending request, a wheel pointer that has just wrapped to zero and an idle port, all at the same edge. Reaching it through the ports alone takes careful sequencing.

The bench requests the swap with the pointer mid-wheel and idles there to show nothing changes. It then drives whole grant rounds until the wheel wraps. It also repeats the swap from a fully idle port at slot 0. Around each swap it sweeps every request pattern against an arithmetic model of both tables, so a write that leaked into the active copy would show up as a wrong winner.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SLOT = 2'd1,
        WIN_PRIO = 2'd2,
        WIN_ROT  = 2'd3
    } win_src_e;

endpackage

// File: rtl/qos_arb_tables.sv
module qos_arb_tables #(
    parameter int N_AGENTS = 4,
    parameter int N_SLOTS  = 16,
    parameter int PRI_W    = 2,
    parameter int CFG_AW   = 5,
    parameter int CFG_DW   = 4,
    parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1,
    parameter int SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [CFG_DW-1:0]         cfg_wdata,
    input  logic                      act_bank,
    input  logic [SLOT_W-1:0]         rd_slot,
    output logic [IDX_W-1:0]          slot_owner,
    output logic [N_AGENTS*PRI_W-1:0] pri_flat
);

    localparam int N_BANKS = 2;

    logic [IDX_W-1:0] slot_q [N_BANKS][N_SLOTS];
    logic [IDX_W-1:0] slot_d [N_BANKS][N_SLOTS];
    logic [PRI_W-1:0] pri_q  [N_BANKS][N_AGENTS];
    logic [PRI_W-1:0] pri_d  [N_BANKS][N_AGENTS];
    logic [CFG_AW-1:0] agent_off;
    logic              shadow;
    logic              unused_bits;

    assign shadow      = ~act_bank;
    assign agent_off   = cfg_addr - CFG_AW'(N_SLOTS);
    assign unused_bits = ^{agent_off, cfg_wdata};

    always_comb begin
        slot_d = slot_q;
        pri_d  = pri_q;
        if (cfg_we) begin
            if (cfg_addr < CFG_AW'(N_SLOTS)) begin
                slot_d[shadow][cfg_addr[SLOT_W-1:0]] = cfg_wdata[IDX_W-1:0];
            end else if (cfg_addr < CFG_AW'(N_SLOTS + N_AGENTS)) begin
                pri_d[shadow][agent_off[IDX_W-1:0]] = cfg_wdata[PRI_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BANKS; b++) begin
                for (int s = 0; s < N_SLOTS; s++) begin
                    slot_q[b][s] <= IDX_W'(s % N_AGENTS);
                end
                for (int a = 0; a < N_AGENTS; a++) begin
                    pri_q[b][a] <= '0;
                end
            end
        end else begin
            slot_q <= slot_d;
            pri_q  <= pri_d;
        end
    end

    assign slot_owner = slot_q[act_bank][rd_slot];

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_pri_out
        assign pri_flat[g*PRI_W +: PRI_W] = pri_q[act_bank][g];
    end

endmodule

// File: rtl/qos_arb_select.sv
module qos_arb_select
    import qos_arb_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int PRI_W    = 2,
    parameter int IDX_W    = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [N_AGENTS-1:0]       req,
    input  logic [IDX_W-1:0]          slot_owner,
    input  logic [N_AGENTS*PRI_W-1:0] pri_flat,
    input  logic [IDX_W-1:0]          rot_last,
    output logic                      win_valid,
    output logic [IDX_W-1:0]          win_idx,
    output win_src_e                  win_src
);

    logic [PRI_W-1:0] pri [N_AGENTS];

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_pri_split
        assign pri[g] = pri_flat[g*PRI_W +: PRI_W];
    end

    logic [PRI_W-1:0] best_lvl;
    logic [IDX_W-1:0] prio_idx;
    logic             prio_hit;
    logic [IDX_W-1:0] rot_idx;
    logic             rot_hit;

    // Highest nonzero level; scanning downward with >= keeps the lowest index on ties.
    always_comb begin
        best_lvl = '0;
        prio_idx = '0;
        prio_hit = 1'b0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (req[IDX_W'(i)] && (pri[IDX_W'(i)] != '0) && (pri[IDX_W'(i)] >= best_lvl)) begin
                best_lvl = pri[IDX_W'(i)];
                prio_idx = IDX_W'(i);
                prio_hit = 1'b1;
            end
        end
    end

    // Rotating search over level-0 requesters, starting after the last rotation winner.
    always_comb begin
        logic [IDX_W-1:0] cand;
        rot_idx = '0;
        rot_hit = 1'b0;
        for (int k = 1; k <= N_AGENTS; k++) begin
            cand = IDX_W'((int'(rot_last) + k) % N_AGENTS);
            if (!rot_hit && req[cand] && (pri[cand] == '0)) begin
                rot_hit = 1'b1;
                rot_idx = cand;
            end
        end
    end

    always_comb begin
        win_valid = 1'b1;
        win_idx   = '0;
        win_src   = WIN_NONE;
        if (req[slot_owner]) begin
            win_idx = slot_owner;
            win_src = WIN_SLOT;
        end else if (prio_hit) begin
            win_idx = prio_idx;
            win_src = WIN_PRIO;
        end else if (rot_hit) begin
            win_idx = rot_idx;
            win_src = WIN_ROT;
        end else begin
            win_valid = 1'b0;
        end
    end

endmodule

// File: rtl/mem_qos_arbiter.sv
module mem_qos_arbiter
    import qos_arb_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int N_SLOTS  = 16,
    parameter int PRI_W    = 2,
    parameter int CFG_AW   = 5,
    parameter int CFG_DW   = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_AGENTS-1:0]   req,
    input  logic [N_AGENTS-1:0]   done,
    output logic [N_AGENTS-1:0]   gnt,
    input  logic                  cfg_we,
    input  logic [CFG_AW-1:0]     cfg_addr,
    input  logic [CFG_DW-1:0]     cfg_wdata,
    output logic                  active_bank,
    output logic                  swap_pending,
    output logic [((N_SLOTS > 1) ? $clog2(N_SLOTS) : 1)-1:0] slot_idx
);

    localparam int IDX_W     = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;
    localparam int SLOT_W    = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam int CTRL_ADDR = N_SLOTS + N_AGENTS;

    typedef struct packed {
        logic [N_AGENTS-1:0] gnt;
        logic [SLOT_W-1:0]   wptr;
        logic [IDX_W-1:0]    rot_last;
        logic                bank;
        logic                swap_pend;
    } arb_state_t;

    arb_state_t state_d, state_q;

    logic [IDX_W-1:0]          slot_owner;
    logic [N_AGENTS*PRI_W-1:0] pri_flat;
    logic                      win_valid;
    logic [IDX_W-1:0]          win_idx;
    win_src_e                  win_src;

    qos_arb_tables #(
        .N_AGENTS(N_AGENTS), .N_SLOTS(N_SLOTS), .PRI_W(PRI_W),
        .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
    ) u_tables (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .act_bank   (state_q.bank),
        .rd_slot    (state_q.wptr),
        .slot_owner (slot_owner),
        .pri_flat   (pri_flat)
    );

    qos_arb_select #(
        .N_AGENTS(N_AGENTS), .PRI_W(PRI_W), .IDX_W(IDX_W)
    ) u_select (
        .req        (req),
        .slot_owner (slot_owner),
        .pri_flat   (pri_flat),
        .rot_last   (state_q.rot_last),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_src    (win_src)
    );

    logic held;
    logic finishing;

    assign held      = |state_q.gnt;
    assign finishing = |(state_q.gnt & (done | ~req));

    always_comb begin
        state_d = state_q;
        if (cfg_we && (cfg_addr == CFG_AW'(CTRL_ADDR)) && cfg_wdata[0]) begin
            state_d.swap_pend = 1'b1;
        end
        if (held) begin
            if (finishing) begin
                state_d.gnt  = '0;
                state_d.wptr = (state_q.wptr == SLOT_W'(N_SLOTS - 1)) ? '0
                                                                     : state_q.wptr + SLOT_W'(1);
            end
        end else if (state_q.swap_pend && (state_q.wptr == '0)) begin
            state_d.bank      = ~state_q.bank;
            state_d.swap_pend = 1'b0;
        end else if (win_valid) begin
            state_d.gnt = N_AGENTS'(1) << win_idx;
            if (win_src == WIN_ROT) begin
                state_d.rot_last = win_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.gnt       <= '0;
            state_q.wptr      <= '0;
            state_q.rot_last  <= IDX_W'(N_AGENTS - 1);
            state_q.bank      <= 1'b0;
            state_q.swap_pend <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign gnt          = state_q.gnt & req;
    assign active_bank  = state_q.bank;
    assign swap_pending = state_q.swap_pend;
    assign slot_idx     = state_q.wptr;

endmodule

// File: rtl/qos_arb_checker.sv
module qos_arb_checker #(
    parameter int N_AGENTS = 4,
    parameter int N_SLOTS  = 16,
    parameter int SLOT_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_AGENTS-1:0] req,
    input logic [N_AGENTS-1:0] done,
    input logic [N_AGENTS-1:0] gnt,
    input logic                active_bank,
    input logic                swap_pending,
    input logic [SLOT_W-1:0]   slot_idx
);

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R1

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & ~done) != '0) |=> ((gnt == $past(gnt)) || ((req & $past(gnt)) == '0))); // R2

    AST_GRANT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & done) != '0) |=> (gnt == '0)); // R2

    AST_WHEEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != $past(slot_idx)) |->
            (slot_idx == (($past(slot_idx) == SLOT_W'(N_SLOTS - 1)) ? '0
                                                                    : $past(slot_idx) + SLOT_W'(1)))); // R6

    AST_SWAP_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (active_bank != $past(active_bank)) |->
            ($past(slot_idx) == '0 && $past(gnt) == '0 && $past(swap_pending))); // R8

    AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swap_pending) |-> (active_bank != $past(active_bank))); // R8

    AST_SWAP_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (active_bank != $past(active_bank)) |-> (gnt == '0)); // R8

endmodule

bind mem_qos_arbiter qos_arb_checker #(
    .N_AGENTS(N_AGENTS), .N_SLOTS(N_SLOTS)
) u_qos_arb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .done         (done),
    .gnt          (gnt),
    .active_bank  (active_bank),
    .swap_pending (swap_pending),
    .slot_idx     (slot_idx)
);

// File: tb/test_mem_qos_arbiter.sv
`timescale 1ns/1ps
module test_mem_qos_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic [3:0] done = '0;
    logic [3:0] gnt;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [3:0] cfg_wdata = '0;
    logic       active_bank;
    logic       swap_pending;
    logic [3:0] slot_idx;

    always #10 clk = ~clk;

    mem_qos_arbiter i_mem_qos_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .done(done), .gnt(gnt),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .active_bank(active_bank), .swap_pending(swap_pending), .slot_idx(slot_idx)
    );

    int n_tests = 0;
    int n_fail  = 0;

    int m_slot [2][16];
    int m_pri  [2][4];
    int m_bank = 0;
    int m_ptr  = 0;
    int m_rot  = 3;
    bit m_pend = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int predict(input logic [3:0] r, output bit via_rot);
        int owner, best, idx;
        via_rot = 0;
        owner = m_slot[m_bank][m_ptr];
        if (r[owner]) return owner;
        best = 0; idx = -1;
        for (int i = 0; i < 4; i++)
            if (r[i] && m_pri[m_bank][i] > best) begin best = m_pri[m_bank][i]; idx = i; end
        if (idx >= 0) return idx;
        for (int k = 1; k <= 4; k++) begin
            if (r[(m_rot + k) % 4] && m_pri[m_bank][(m_rot + k) % 4] == 0) begin
                via_rot = 1;
                return (m_rot + k) % 4;
            end
        end
        return -1;
    endfunction

    // One full access: raise requests, check the winner, hold, finish, check release.
    task automatic grant_round(input logic [3:0] r, input string rq);
        int exp;
        bit via_rot;
        int waited;
        logic [3:0] seen;
        @(negedge clk);
        req = r;
        if (m_pend && m_ptr == 0) begin m_bank ^= 1; m_pend = 0; end
        exp = predict(r, via_rot);
        waited = 0;
        while (gnt == '0 && waited < 10) begin @(negedge clk); waited++; end
        check(gnt == 4'(1 << exp), rq, int'(gnt), 1 << exp);
        seen = gnt;
        @(negedge clk);
        check(gnt == seen, "R2 hold", int'(gnt), int'(seen));
        done = seen;
        @(negedge clk);
        check(gnt == '0, "R2 release", int'(gnt), 0);
        done = '0;
        req  = '0;
        m_ptr = (m_ptr + 1) % 16;
        if (via_rot) m_rot = exp;
        check(int'(slot_idx) == m_ptr, "R6 wheel step", int'(slot_idx), m_ptr);
    endtask

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 4'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 16) m_slot[m_bank ^ 1][a] = d % 4;
        else if (a < 20) m_pri[m_bank ^ 1][a - 16] = d % 4;
        else if (d % 2 == 1) m_pend = 1;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) begin
            for (int s = 0; s < 16; s++) m_slot[b][s] = s % 4;
            for (int a = 0; a < 4; a++) m_pri[b][a] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(gnt == '0, "R9 gnt", int'(gnt), 0);
        check(active_bank == 1'b0, "R9 bank", int'(active_bank), 0);
        check(swap_pending == 1'b0, "R9 pending", int'(swap_pending), 0);
        check(slot_idx == '0, "R9 slot", int'(slot_idx), 0);

        // R9 R3: default wheel hands slots to agents in turn
        for (int i = 0; i < 4; i++) grant_round(4'hF, "R3 default wheel");
        // R3 R5 sweep with default tables
        for (int p = 0; p < 30; p++) grant_round(4'((p % 15) + 1), "R5 default sweep");

        // R7: load the inactive copy; arbitration must still follow the active one
        for (int s = 0; s < 16; s++) cfg_write(s, (s * 3) % 4);
        cfg_write(16, 0); cfg_write(17, 2); cfg_write(18, 2); cfg_write(19, 0);
        check(swap_pending == 1'b0, "R7 no swap from table writes", int'(swap_pending), 0);
        for (int p = 0; p < 8; p++) grant_round(4'((p * 7 % 15) + 1), "R7 inactive untouched");

        // R8: swap request mid-wheel waits for the wrap
        cfg_write(20, 1);
        check(swap_pending == 1'b1, "R8 pending set", int'(swap_pending), 1);
        repeat (4) @(negedge clk);
        check(active_bank == 1'b0, "R8 no early swap", int'(active_bank), 0);
        check(swap_pending == 1'b1, "R8 still pending", int'(swap_pending), 1);
        while (m_ptr != 0) grant_round(4'hF, "R3 run to wrap");
        grant_round(4'h6, "R4 first after swap");
        check(active_bank == 1'b1, "R8 swapped", int'(active_bank), 1);
        check(swap_pending == 1'b0, "R8 pending cleared", int'(swap_pending), 0);

        // R3 R4 R5 with the new table
        for (int p = 0; p < 45; p++) grant_round(4'((p % 15) + 1), "R4 new table sweep");

        // R7 R8: rewrite the other copy and swap back
        for (int s = 0; s < 16; s++) cfg_write(s, 2);
        cfg_write(16, 1); cfg_write(17, 0); cfg_write(18, 3); cfg_write(19, 0);
        cfg_write(20, 1);
        for (int p = 0; p < 20; p++) grant_round(4'(((p * 4) % 15) + 1), "R5 second table sweep");
        check(active_bank == 1'b0, "R8 swapped back", int'(active_bank), 0);

        // R8: swap from an idle port at slot 0
        while (m_ptr != 0) grant_round(4'hB, "R4 run to wrap");
        cfg_write(20, 1);
        @(negedge clk);
        m_bank ^= 1; m_pend = 0;
        check(active_bank == 1'b1, "R8 idle swap", int'(active_bank), 1);
        check(swap_pending == 1'b0, "R8 idle swap clears", int'(swap_pending), 0);
        check(gnt == '0, "R8 no grant on swap", int'(gnt), 0);
        for (int p = 0; p < 15; p++) grant_round(4'(p + 1), "R1 final sweep");

        summary();
        $finish;
    end

endmodule